// File: doc/BRIEF.md
# Light-Sleep Entry and Peripheral Clock-Gating Controller

This block decides when a processor subsystem stops its core clock and enters a light sleep, when it wakes, and which peripheral clocks keep running while it sleeps. Three strobes from the core can start a sleep: a wait-for-interrupt strobe, a wait-for-event strobe, and a handler-return strobe. The handler-return strobe only starts a sleep when the sleep-on-exit bit is set. Entry is refused whenever anything that would end the sleep at once is already pending. When the deep-sleep select bit is set, an accepted request does not start a light sleep. Instead the block sends a one-cycle request to a separate deep-sleep sequencer.

Each peripheral has a run enable and a low-power enable. The peripherals are grouped by bus, and the enables are flattened into one vector with bus 0 in the low bits. In run mode a peripheral clock follows its run enable. In sleep it runs only when both of its enables are set. Every clock enable output is taken straight from a flip-flop, so it changes only at a clock edge and can drive a latch-based clock gate downstream. All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `slp_ctrl`

## Requirements
- R1: While reset is held and after it is released, `core_clk_en` is 1, `sleeping` is 0, `deep_req` is 0 and `periph_clk_en` is all zeros.
- R2: When `wfi` is 1, `deep_sel` is 0 and `irq_pend` is all zeros in a cycle spent running, `sleeping` reads 1 and `core_clk_en` reads 0 after the next rising edge.
- R3: `wfe` enters sleep only when `deep_sel` is 0, no interrupt is pending and no event is pending. An event is pending when `evt` is 1 in that cycle or an earlier event is still held. A `wfe` refused only because an event is pending clears the held event, so the next `wfe` can sleep.
- R4: `hret` enters sleep when `sleep_on_exit` is 1, `deep_sel` is 0 and no interrupt is pending. With `sleep_on_exit` at 0 it has no effect.
- R5: Any set bit of `irq_pend` blocks entry by every strobe. The block stays in run mode and `core_clk_en` stays 1. When several strobes arrive in the same cycle, `wfi` takes precedence over `wfe`, and `wfe` over `hret`.
- R6: A sleep started by `wfi` or `hret` ends at the first rising edge that sees any bit of `irq_pend` set. `evt` does not end it.
- R7: A sleep started by `wfe` ends at the first rising edge that sees `evt` at 1 or any bit of `irq_pend` set. That event is consumed.
- R8: In run mode, each bit of `periph_clk_en` equals the matching bit of `run_en` as sampled at the previous rising edge.
- R9: In sleep, each bit of `periph_clk_en` equals the AND of the matching bits of `run_en` and `lp_en` as sampled at the previous rising edge.
- R10: A request that would be accepted while `deep_sel` is 1 leaves `sleeping` at 0 and makes `deep_req` 1 for the following cycle only.
- R11: `core_clk_en` is always the inverse of `sleeping`. Strobes that arrive while asleep are ignored.
- R12: An `evt` that arrives while running, or during a sleep started by `wfi` or `hret`, is held. A later `wfe` then does not enter sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that is never gated |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi | input | 1 | Wait-for-interrupt strobe |
| wfe | input | 1 | Wait-for-event strobe |
| hret | input | 1 | Handler-return strobe |
| deep_sel | input | 1 | 1 = a request asks for deep sleep instead of light sleep |
| sleep_on_exit | input | 1 | 1 = sleep automatically on handler return |
| irq_pend | input | NIRQ | Enabled pending interrupts, one bit each |
| evt | input | 1 | Event input, one cycle per event |
| run_en | input | NBUS*PER_BUS | Run-mode peripheral clock enables |
| lp_en | input | NBUS*PER_BUS | Sleep-mode peripheral clock enables |
| core_clk_en | output | 1 | Core clock enable, registered |
| periph_clk_en | output | NBUS*PER_BUS | Gated peripheral clock enables, registered |
| sleeping | output | 1 | 1 while in light sleep |
| deep_req | output | 1 | One-cycle deep-sleep request |

## Verification
On every cycle the assertions check several relations. `core_clk_en` must stay the inverse of `sleeping`. A pending interrupt must keep a running block awake, and must end any sleep at the next edge. An event must end a sleep that was started by `wfe`. A deep-sleep request must never come with a light sleep. In sleep, a peripheral whose low-power enable is clear must have its clock stopped.

Some behaviours depend on history and on timing, and only the bench's scenarios can show them. These are the held event that refuses a later `wfe` and is then consumed, the priority between strobes that arrive together, the one-cycle lag of the peripheral enables behind `run_en` and `lp_en`, and the fact that strobes are ignored during sleep.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_SLEEP = 1'b1
  } pwr_state_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_WFI  = 2'd1,
    SRC_WFE  = 2'd2,
    SRC_RET  = 2'd3
  } sleep_src_e;
endpackage

// File: rtl/slp_entry_ctl.sv
module slp_entry_ctl
  import slp_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_i,
  input  logic            wfe_i,
  input  logic            ret_i,
  input  logic            deep_sel_i,
  input  logic            exit_en_i,
  input  logic [NIRQ-1:0] irq_pend_i,
  input  logic            evt_i,
  output logic            sleep_nxt_o,
  output logic            sleep_q_o,
  output logic            deep_req_o
);
  pwr_state_e state_q, state_d;
  sleep_src_e src_q, src_d, req_src;
  logic       evt_held_q, evt_held_d;
  logic       deep_q;
  logic       irq_any, evt_pend, running;
  logic       allowed, enter, deep_go, consume, wake, wfe_sleep;

  assign irq_any   = |irq_pend_i;
  assign evt_pend  = evt_held_q | evt_i;
  assign running   = (state_q == ST_RUN);
  assign wfe_sleep = (state_q == ST_SLEEP) && (src_q == SRC_WFE);

  // strobe priority: wfi, then wfe, then handler return
  always_comb begin
    if (wfi_i)                 req_src = SRC_WFI;
    else if (wfe_i)            req_src = SRC_WFE;
    else if (ret_i && exit_en_i) req_src = SRC_RET;
    else                       req_src = SRC_NONE;
  end

  always_comb begin
    allowed = running && (req_src != SRC_NONE) && !irq_any &&
              !((req_src == SRC_WFE) && evt_pend);
    enter   = allowed && !deep_sel_i;
    deep_go = allowed && deep_sel_i;
    consume = running && (req_src == SRC_WFE) && !irq_any && evt_pend;
    wake    = (state_q == ST_SLEEP) && (irq_any || (wfe_sleep && evt_i));
  end

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    if (running && enter) begin
      state_d = ST_SLEEP;
      src_d   = req_src;
    end else if (wake) begin
      state_d = ST_RUN;
      src_d   = SRC_NONE;
    end
  end

  always_comb begin
    evt_held_d = evt_held_q;
    if (consume)
      evt_held_d = 1'b0;
    else if (evt_i && !wfe_sleep)
      evt_held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      src_q      <= SRC_NONE;
      evt_held_q <= 1'b0;
      deep_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      src_q      <= src_d;
      evt_held_q <= evt_held_d;
      deep_q     <= deep_go;
    end
  end

  assign sleep_nxt_o = (state_d == ST_SLEEP);
  assign sleep_q_o   = (state_q == ST_SLEEP);
  assign deep_req_o  = deep_q;

  AST_IRQ_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && irq_any) |=> (state_q == ST_RUN)); // R5
  AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SLEEP) && irq_any) |=> (state_q == ST_RUN)); // R6
  AST_EVT_WAKES_WFE: assert property (@(posedge clk) disable iff (!rst_n)
    (wfe_sleep && evt_i) |=> (state_q == ST_RUN)); // R7
  AST_DEEP_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    deep_req_o |-> (state_q == ST_RUN)); // R10
endmodule

// File: rtl/slp_gate_cell.sv
module slp_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_nxt_i,
  input  logic run_i,
  input  logic lp_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= sleep_nxt_i ? (run_i & lp_i) : run_i;
  end

  assign en_o = en_q;

  AST_LP_STOPS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_nxt_i && !lp_i) |=> !en_o); // R9
endmodule

// File: rtl/slp_clk_gate_bank.sv
module slp_clk_gate_bank #(
  parameter int NBUS    = 3,
  parameter int PER_BUS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sleep_nxt_i,
  input  logic [NBUS*PER_BUS-1:0] run_en_i,
  input  logic [NBUS*PER_BUS-1:0] lp_en_i,
  output logic [NBUS*PER_BUS-1:0] periph_en_o,
  output logic                    core_en_o
);
  logic core_q;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    for (genvar s = 0; s < PER_BUS; s++) begin : g_slot
      localparam int IDX = b * PER_BUS + s;
      slp_gate_cell u_cell (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_nxt_i (sleep_nxt_i),
        .run_i       (run_en_i[IDX]),
        .lp_i        (lp_en_i[IDX]),
        .en_o        (periph_en_o[IDX])
      );
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_q <= 1'b1;
    else        core_q <= !sleep_nxt_i;
  end

  assign core_en_o = core_q;
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl #(
  parameter int NIRQ    = 8,
  parameter int NBUS    = 3,
  parameter int PER_BUS = 8,
  localparam int NPER   = NBUS * PER_BUS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi,
  input  logic            wfe,
  input  logic            hret,
  input  logic            deep_sel,
  input  logic            sleep_on_exit,
  input  logic [NIRQ-1:0] irq_pend,
  input  logic            evt,
  input  logic [NPER-1:0] run_en,
  input  logic [NPER-1:0] lp_en,
  output logic            core_clk_en,
  output logic [NPER-1:0] periph_clk_en,
  output logic            sleeping,
  output logic            deep_req
);
  logic sleep_nxt;

  slp_entry_ctl #(.NIRQ(NIRQ)) u_entry (
    .clk         (clk),
    .rst_n       (rst_n),
    .wfi_i       (wfi),
    .wfe_i       (wfe),
    .ret_i       (hret),
    .deep_sel_i  (deep_sel),
    .exit_en_i   (sleep_on_exit),
    .irq_pend_i  (irq_pend),
    .evt_i       (evt),
    .sleep_nxt_o (sleep_nxt),
    .sleep_q_o   (sleeping),
    .deep_req_o  (deep_req)
  );

  slp_clk_gate_bank #(.NBUS(NBUS), .PER_BUS(PER_BUS)) u_gates (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_nxt_i (sleep_nxt),
    .run_en_i    (run_en),
    .lp_en_i     (lp_en),
    .periph_en_o (periph_clk_en),
    .core_en_o   (core_clk_en)
  );

  AST_CORE_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en == !sleeping); // R11
endmodule

// File: tb/slp_ctrl_test.sv
module slp_ctrl_test;
  localparam int NIRQ = 8;
  localparam int NPER = 24;
  localparam int NVEC = 18;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wfi = 0, wfe = 0, hret = 0, deep_sel = 0, sleep_on_exit = 0, evt = 0;
  logic [NIRQ-1:0] irq_pend = '0;
  logic [NPER-1:0] run_en = '0, lp_en = '0;
  logic            core_clk_en, sleeping, deep_req;
  logic [NPER-1:0] periph_clk_en;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wfi(wfi), .wfe(wfe), .hret(hret),
    .deep_sel(deep_sel), .sleep_on_exit(sleep_on_exit), .irq_pend(irq_pend),
    .evt(evt), .run_en(run_en), .lp_en(lp_en), .core_clk_en(core_clk_en),
    .periph_clk_en(periph_clk_en), .sleeping(sleeping), .deep_req(deep_req)
  );

  // fields: [15]wfi [14]wfe [13]hret [12]deep_sel [11]sleep_on_exit [10]evt
  //         [9:2]irq_pend [1]expected sleeping [0]expected deep_req
  localparam logic [15:0] VEC [NVEC] = '{
    16'b0_0_0_0_0_0_00000000_0_0, // R1 idle
    16'b1_0_0_0_0_0_00000000_1_0, // R2 wfi enters
    16'b0_0_0_0_0_1_00000000_1_0, // R6 evt does not wake, held (R12)
    16'b0_0_0_0_0_0_00000001_0_0, // R6 irq wakes
    16'b0_1_0_0_0_0_00000000_0_0, // R12 held event refuses wfe, consumed
    16'b0_1_0_0_0_0_00000000_1_0, // R3 wfe enters
    16'b0_0_0_0_0_1_00000000_0_0, // R7 evt wakes
    16'b1_0_0_0_0_0_00000100_0_0, // R5 irq blocks wfi
    16'b0_0_1_0_0_0_00000000_0_0, // R4 no sleep-on-exit
    16'b0_0_1_0_1_0_00000000_1_0, // R4 hret enters
    16'b1_0_0_0_1_0_00000000_1_0, // R11 strobe ignored while asleep
    16'b0_0_0_0_0_0_10000000_0_0, // R6 top irq wakes
    16'b1_0_0_1_0_0_00000000_0_1, // R10 deep request
    16'b0_0_0_0_0_0_00000000_0_0, // R10 pulse ends
    16'b0_1_0_0_0_0_00000010_0_0, // R5 irq blocks wfe
    16'b0_1_0_0_0_1_00000000_0_0, // R3 same-cycle event refuses wfe
    16'b0_1_0_0_0_0_00000000_1_0, // R3 wfe enters after consume
    16'b0_0_0_0_0_0_00010000_0_0  // R7 irq wakes wfe sleep
  };
  localparam int VREQ [NVEC] = '{1,2,6,6,12,3,7,5,4,4,11,6,10,10,5,3,3,7};

  task automatic chk(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    run_en = 24'hA5_3C_F0;
    lp_en  = 24'h0F_FF_33;
    repeat (3) tick();
    // R1 during reset
    chk(1, "core_clk_en in reset", core_clk_en, 1);
    chk(1, "sleeping in reset", sleeping, 0);
    chk(1, "deep_req in reset", deep_req, 0);
    chk(1, "periph_clk_en in reset", periph_clk_en, 0);
    rst_n = 1'b1;
    tick();
    // R8: run follows run_en
    chk(8, "periph run", periph_clk_en, 24'hA5_3C_F0);
    run_en = 24'h12_34_56;
    tick();
    chk(8, "periph run after change", periph_clk_en, 24'h12_34_56);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      {wfi, wfe, hret, deep_sel, sleep_on_exit, evt} = VEC[i][15:10];
      irq_pend = VEC[i][9:2];
      tick();
      {wfi, wfe, hret, deep_sel, sleep_on_exit, evt} = '0;
      irq_pend = '0;
      chk(VREQ[i], $sformatf("vec %0d sleeping", i), sleeping, VEC[i][1]);
      chk(VREQ[i], $sformatf("vec %0d deep_req", i), deep_req, VEC[i][0]);
      chk(11, $sformatf("vec %0d core_clk_en", i), core_clk_en, !VEC[i][1]);
    end

    // R9: gating in sleep, then R8 after wake
    run_en = 24'hFF_F0_0F;
    lp_en  = 24'h0F_33_FF;
    wfi = 1'b1;
    tick();
    wfi = 1'b0;
    chk(2, "wfi sleep entered", sleeping, 1);
    chk(9, "periph in sleep", periph_clk_en, 24'hFF_F0_0F & 24'h0F_33_FF);
    lp_en = 24'h00_00_01;
    tick();
    chk(9, "periph in sleep after lp change", periph_clk_en, 24'h00_00_01);
    irq_pend = 8'h08;
    tick();
    irq_pend = '0;
    chk(6, "irq wake", sleeping, 0);
    chk(8, "periph after wake", periph_clk_en, 24'hFF_F0_0F);

    // R5 priority: wfi with wfe together while event pending -> wfi wins, sleeps
    wfi = 1'b1; wfe = 1'b1; evt = 1'b1;
    tick();
    wfi = 1'b0; wfe = 1'b0; evt = 1'b0;
    chk(5, "wfi priority over wfe", sleeping, 1);
    evt = 1'b1;
    tick();
    evt = 1'b0;
    chk(6, "evt no wake from wfi", sleeping, 1);
    irq_pend = 8'h01;
    tick();
    irq_pend = '0;
    wfe = 1'b1;
    tick();
    wfe = 1'b0;
    chk(12, "held event refuses wfe", sleeping, 0);

    // R1: reset while asleep
    hret = 1'b1; sleep_on_exit = 1'b1;
    tick();
    hret = 1'b0; sleep_on_exit = 1'b0;
    chk(4, "hret sleep", sleeping, 1);
    rst_n = 1'b0;
    tick();
    chk(1, "reset from sleep core_clk_en", core_clk_en, 1);
    chk(1, "reset from sleep sleeping", sleeping, 0);
    rst_n = 1'b1;
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule